// File: doc/BRIEF.md
# Transmit Timestamp Record/Event Pairing

This block sits beside a transmit MII timestamp interface. At the start of every outgoing packet it sees a one-cycle record pulse. At that pulse it captures the current value of a free-running timestamp counter into a single pending slot. If the packet was classified as a time-sync event packet, a one-cycle event pulse carrying a 3-bit handle follows before the next record pulse. The block then pairs the pending timestamp with that handle and pushes the pair into a small output FIFO.

Pairing relies only on the order of the pulses. A packet that does not qualify produces no event pulse. Its capture is then overwritten by the next record and never reaches the output. The FIFO drains through a valid/ready stream of {handle, timestamp}. Two sticky flags report protocol faults: an event that arrives with no pending record, and an entry lost to a full FIFO.

Top module: `tx_ts_pair`

## Requirements
- R1: When `rec_i` is high at a clock edge, the pending slot becomes valid and holds the value of `ts_i` sampled at that edge.
- R2: When `evt_i` is high at an edge while the slot is valid, one entry {`hndl_i`, pending timestamp} is queued. If `rec_i` is not also high, the slot becomes empty.
- R3: When a second record arrives with no event in between, the earlier capture is discarded. The next event carries the timestamp of the later record.
- R4: An event at an edge where the slot is empty queues nothing and sets `orphan_err`. The flag stays set until reset.
- R5: When record and event are high at the same edge, the event is paired with the timestamp already pending. A new pending slot then opens with the current `ts_i`.
- R6: The FIFO holds DEPTH (8) entries. If a push arrives while it holds DEPTH entries (counted before any pop at the same edge), that push is dropped, the stored entries are kept intact, and `ovf_err` is set and stays set until reset.
- R7: Entries leave in the order they were queued. `out_valid` is high whenever the FIFO is non-empty. A queued entry is visible at the outputs in the cycle after its event edge. An entry is removed at an edge where `out_valid` and `out_ready` are both high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_hndl` and `out_ts` hold their values.
- R9: After reset the FIFO is empty, no record is pending, and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_i | input | 1 | One-cycle record pulse at packet start |
| evt_i | input | 1 | One-cycle event pulse for a time-sync packet |
| hndl_i | input | HNDL_W (3) | Handle that accompanies the event pulse |
| ts_i | input | TS_W (32) | Free-running timestamp counter value |
| out_valid | output | 1 | Output entry available |
| out_ready | input | 1 | Consumer accepts the entry |
| out_hndl | output | HNDL_W (3) | Handle of the head entry |
| out_ts | output | TS_W (32) | Timestamp of the head entry |
| orphan_err | output | 1 | Sticky: an event arrived with nothing pending |
| ovf_err | output | 1 | Sticky: an entry was dropped because the FIFO was full |

## Verification
The bench goes after the ordering corners.

- **Double record.** A design that kept the first capture would report an old timestamp.
- **Simultaneous record and event.** A design that let the new record win would pair the handle with the wrong packet and lose the earlier one.
- **Orphan event.** A design that queued anyway would emit an entry with stale data.
- **Push into a full FIFO while a pop occurs at the same edge.** A design that accepted that push, or that overwrote the oldest entry, would produce a sequence that differs from the arithmetic model.

Handles and record-to-event gaps are swept exhaustively while the ready pattern changes, so that stalls meet pushes in every phase.

// File: rtl/tx_ts_pair.sv
module tx_ts_pair #(
  parameter int TS_W   = 32,
  parameter int HNDL_W = 3,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_i,
  input  logic              evt_i,
  input  logic [HNDL_W-1:0] hndl_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HNDL_W-1:0] out_hndl,
  output logic [TS_W-1:0]   out_ts,
  output logic              orphan_err,
  output logic              ovf_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = HNDL_W + TS_W;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic            pend_v;
  logic [TS_W-1:0] pend_ts;
  logic [EW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [AW:0]     count;

  wire full     = (count == FULL_CNT);
  wire push_req = evt_i & pend_v;
  wire push     = push_req & ~full;
  wire pop      = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_v  <= 1'b0;
      pend_ts <= '0;
    end else if (rec_i) begin
      pend_v  <= 1'b1;
      pend_ts <= ts_i;
    end else if (evt_i) begin
      pend_v  <= 1'b0;
    end

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= {hndl_i, pend_ts};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      orphan_err <= 1'b0;
      ovf_err    <= 1'b0;
    end else begin
      if (evt_i && !pend_v) orphan_err <= 1'b1;
      if (push_req && full) ovf_err    <= 1'b1;
    end

  assign out_valid          = (count != '0);
  assign {out_hndl, out_ts} = mem[rd_ptr];

  AST_REC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_i |=> pend_v && pend_ts == $past(ts_i)); // R1
  AST_EVT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i && !rec_i |=> !pend_v); // R2
  AST_ORPHAN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i && !pend_v |=> orphan_err); // R4
  AST_ORPHAN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    orphan_err |=> orphan_err); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ts) && $stable(out_hndl)); // R8
endmodule

// File: tb/test_tx_ts_pair.sv
module test_tx_ts_pair;
  logic clk = 0, rst_n = 0;
  logic rec_i = 0, evt_i = 0, out_ready = 0;
  logic [2:0] hndl_i = 0;
  logic [31:0] ts_i = 32'h1000_0000;
  logic out_valid, orphan_err, ovf_err;
  logic [2:0] out_hndl;
  logic [31:0] out_ts;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [34:0] q[$];
  bit m_pv = 0, m_orph = 0, m_ovf = 0;
  logic [31:0] m_pts = 0;

  always #4 clk = ~clk;
  always @(posedge clk) ts_i <= ts_i + 32'd3;

  tx_ts_pair i_tx_ts_pair (.clk, .rst_n, .rec_i, .evt_i, .hndl_i, .ts_i,
    .out_valid, .out_ready, .out_hndl, .out_ts, .orphan_err, .ovf_err);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit r, bit e, logic [2:0] h, bit rdy, string tag);
    int sz;
    rec_i = r; evt_i = e; hndl_i = h; out_ready = rdy;
    #1;
    sz = q.size();
    chk({tag, " valid"}, 64'(out_valid), 64'(sz != 0));
    if (sz != 0) chk({tag, " head"}, 64'({out_hndl, out_ts}), 64'(q[0]));
    if (e) begin
      if (m_pv) begin
        if (sz == 8) m_ovf = 1;
        else q.push_back({h, m_pts});
      end else m_orph = 1;
    end
    if (out_valid && rdy && sz != 0) void'(q.pop_front());
    if (r) begin m_pv = 1; m_pts = ts_i; end
    else if (e) m_pv = 0;
    @(posedge clk); @(negedge clk);
    chk("R4 orphan_err", 64'(orphan_err), 64'(m_orph));
    chk("R6 ovf_err", 64'(ovf_err), 64'(m_ovf));
  endtask

  task automatic drain(string tag);
    for (int k = 0; k < 20 && q.size() != 0; k++) step(0, 0, 0, 1, tag);
    step(0, 0, 0, 1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 valid", 64'(out_valid), 0);
    chk("R9 orphan", 64'(orphan_err), 0);
    chk("R9 ovf", 64'(ovf_err), 0);
    rst_n = 1;
    @(negedge clk);
    // R1 R2 basic pairing
    step(1, 0, 0, 0, "R1");
    step(0, 0, 0, 0, "R1");
    step(0, 1, 3'd5, 0, "R2");
    step(0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, "R8");
    drain("R7");
    // R3 double record
    step(1, 0, 0, 1, "R3");
    step(1, 0, 0, 1, "R3");
    step(0, 1, 3'd2, 1, "R3");
    drain("R3");
    // R5 simultaneous record and event
    step(1, 0, 0, 1, "R5");
    step(1, 1, 3'd6, 1, "R5");
    step(0, 1, 3'd1, 1, "R5");
    drain("R5");
    // R4 orphan event
    step(0, 1, 3'd7, 1, "R4");
    chk("R4 no entry", 64'(out_valid), 0);
    // R7 R8 sweep of handle and gap under varying ready
    for (int h = 0; h < 8; h++)
      for (int g = 0; g < 4; g++) begin
        step(1, 0, 0, (h + g) % 3 != 0, "R7");
        for (int k = 0; k < g; k++) step(0, 0, 0, k % 2 == 0, "R8");
        step(0, 1, 3'(h), (h + g) % 2 == 0, "R7");
      end
    drain("R7");
    // R6 overflow with stalled output
    for (int k = 0; k < 9; k++) begin
      step(1, 0, 0, 0, "R6");
      step(0, 1, 3'(k), 0, "R6");
    end
    // R6 push into full FIFO at same edge as a pop
    step(1, 0, 0, 0, "R6");
    step(0, 1, 3'd4, 1, "R6");
    drain("R6");
    chk("R6 flag kept", 64'(ovf_err), 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule